// File: doc/BRIEF.md
# Two-Axis Zero-Bit-Skipping Dot-Product Tile

The block forms the dot product of sixteen unsigned 16-bit weights with sixteen unsigned 16-bit activations. It works only on the set bits of the weights. The weights are held as a square bit matrix with one weight per row and one bit position per column. Each accepted schedule entry clears one line of that matrix. A column entry handles one bit position across all weights, which is bit-serial work. A row entry handles every bit of one weight, which is bit-parallel work. The schedule is computed ahead of time, and the block takes one entry per cycle through a valid/ready pair.

Sixteen lanes work on the chosen line. If a lane has no pending bit on that line, it does not sit idle. It takes a pending bit on its own line along the other axis: the lowest pending bit of its weight in column mode, or the lowest-numbered weight with its bit pending in row mode. No pivot can collide with a bit claimed on the main line. Every consumed bit is cleared from a pending mask. Once the mask is empty, `done` is raised and the schedule stream is refused.

Top module: `hybrid_bitskip_tile`

## Requirements
- R1: After reset, `done`, `md_ready` and `acc_out` are 0. A one-cycle `start` pulse loads the weights, the activations and the pending mask, and clears `acc_out` to 0 at the next edge. `md_ready` is low in a cycle where `start` is high.
- R2: An accepted entry with `md_dir`=0 (column) and `md_idx`=j adds act[i]<<j for every weight i whose bit j is pending. Afterwards column j holds no pending bit.
- R3: An accepted entry with `md_dir`=1 (row) and `md_idx`=r adds act[r]<<k for every pending bit k of weight r. Afterwards row r holds no pending bit.
- R4: In column mode, a lane i whose weight has no pending bit at position j adds act[i]<<b, where b is the lowest pending bit of weight i, and clears that bit.
- R5: In row mode, a lane k whose bit k of weight r is not pending adds act[w]<<k, where w is the lowest-numbered weight with bit k pending, and clears that bit.
- R6: Each set weight bit is consumed exactly once. When `done` rises, `acc_out` equals the sum of act[i]*w[i] (40-bit), and the number of accepted entries is at most the number of set bits.
- R7: `done` is 1 exactly when a tile is loaded and its mask is empty. While `done` is 1, `md_ready` is 0 and offered entries leave `acc_out` unchanged.
- R8: An entry that names an already-empty line still performs all possible pivot work, so every accepted entry clears at least one bit.
- R9: A tile whose weights are all zero raises `done` in the first cycle after `start`, with `acc_out` equal to 0.
- R10: `acc_out` changes only on an accepted entry or on `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load a new tile and clear the sum |
| wt_in | input | 256 | Weights; weight i sits at bits [16i+15:16i] |
| act_in | input | 256 | Activations; activation i sits at bits [16i+15:16i] |
| md_valid | input | 1 | Schedule entry offered |
| md_ready | output | 1 | Entry accepted this cycle when valid |
| md_dir | input | 1 | 0 = column (bit position), 1 = row (weight) |
| md_idx | input | 4 | Line index |
| acc_out | output | 40 | Accumulated dot product |
| done | output | 1 | All set bits consumed |

## Verification
Directed tiles isolate each mechanism. A two-weight column case shows main-line claims and then a pivot onto a lower bit. A dense row sharing a column with another weight shows that the main line blocks a pivot until a later entry. Single-bit cases aimed at empty lines expose the pivot choice in each axis. Random, sparse, all-ones-row, all-ones-column, all-zero and full-matrix tiles are driven with random schedules. These separate a wrong shift or a wrong choice of activation, which changes the sum, from double or missed consumption, which changes the sum or the count of accepted entries against the set-bit total.

// File: rtl/hbt_pkg.sv
package hbt_pkg;
  localparam int TILE_N = 16;
  localparam int ACT_W  = 16;
  localparam int ACC_W  = 40;

  typedef enum logic {
    DIR_COL = 1'b0,
    DIR_ROW = 1'b1
  } line_dir_e;
endpackage

// File: rtl/hbt_lane.sv
module hbt_lane
  import hbt_pkg::*;
#(
  parameter int N     = TILE_N,
  parameter int AW    = ACT_W,
  parameter int SW    = ACC_W,
  parameter int LANE  = 0,
  localparam int IW   = $clog2(N)
) (
  input  line_dir_e             dir,
  input  logic [IW-1:0]         idx,
  input  logic [N-1:0]          own_row,
  input  logic [N-1:0]          own_col,
  input  logic [N-1:0][AW-1:0]  acts,
  output logic                  hit,
  output logic                  pivot,
  output logic [IW-1:0]         w_sel,
  output logic [IW-1:0]         b_sel,
  output logic [SW-1:0]         term
);
  localparam logic [IW-1:0] SELF = IW'(LANE);

  function automatic logic [IW-1:0] lowest_set(input logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = IW'(i);
    end
    return r;
  endfunction

  function automatic logic [SW-1:0] shifted(input logic [AW-1:0] a,
                                            input logic [IW-1:0] s);
    return SW'(a) << s;
  endfunction

  always_comb begin
    hit   = 1'b0;
    pivot = 1'b0;
    w_sel = SELF;
    b_sel = idx;
    if (dir == DIR_COL) begin
      if (own_row[idx]) begin
        hit   = 1'b1;
        b_sel = idx;
      end else if (|own_row) begin
        hit   = 1'b1;
        pivot = 1'b1;
        b_sel = lowest_set(own_row);
      end
    end else begin
      b_sel = SELF;
      if (own_col[idx]) begin
        hit   = 1'b1;
        w_sel = idx;
      end else if (|own_col) begin
        hit   = 1'b1;
        pivot = 1'b1;
        w_sel = lowest_set(own_col);
      end
    end
  end

  assign term = hit ? shifted(acts[w_sel], b_sel) : '0;
endmodule

// File: rtl/hbt_sum.sv
module hbt_sum #(
  parameter int N  = 16,
  parameter int SW = 40
) (
  input  logic [N-1:0][SW-1:0] terms,
  output logic [SW-1:0]        total
);
  always_comb begin
    total = '0;
    for (int i = 0; i < N; i++) total = total + terms[i];
  end
endmodule

// File: rtl/hybrid_bitskip_tile.sv
module hybrid_bitskip_tile
  import hbt_pkg::*;
#(
  parameter int N    = TILE_N,
  parameter int AW   = ACT_W,
  parameter int SW   = ACC_W,
  localparam int IW  = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [N*N-1:0]    wt_in,
  input  logic [N*AW-1:0]   act_in,
  input  logic              md_valid,
  output logic              md_ready,
  input  logic              md_dir,
  input  logic [IW-1:0]     md_idx,
  output logic [SW-1:0]     acc_out,
  output logic              done
);
  logic [N-1:0][N-1:0]  mask_q;
  logic [N-1:0][AW-1:0] act_q;
  logic [SW-1:0]        acc_q;
  logic                 loaded_q;

  line_dir_e            dir;
  logic                 fire;
  logic                 mask_empty;
  logic [N-1:0][N-1:0]  col_view;
  logic [N-1:0][N-1:0]  clr_bits;
  logic [N-1:0]         lane_hit;
  logic [N-1:0]         lane_pivot;
  logic [N-1:0][IW-1:0] lane_w;
  logic [N-1:0][IW-1:0] lane_b;
  logic [N-1:0][SW-1:0] lane_term;
  logic [SW-1:0]        step_sum;

  assign dir        = line_dir_e'(md_dir);
  assign mask_empty = (mask_q == '0);
  assign md_ready   = !start && !mask_empty;
  assign fire       = md_valid && md_ready;
  assign done       = loaded_q && mask_empty;
  assign acc_out    = acc_q;

  for (genvar w = 0; w < N; w++) begin : g_tr
    for (genvar b = 0; b < N; b++) begin : g_bit
      assign col_view[b][w] = mask_q[w][b];
    end
  end

  for (genvar l = 0; l < N; l++) begin : g_lane
    hbt_lane #(.N(N), .AW(AW), .SW(SW), .LANE(l)) u_lane (
      .dir     (dir),
      .idx     (md_idx),
      .own_row (mask_q[l]),
      .own_col (col_view[l]),
      .acts    (act_q),
      .hit     (lane_hit[l]),
      .pivot   (lane_pivot[l]),
      .w_sel   (lane_w[l]),
      .b_sel   (lane_b[l]),
      .term    (lane_term[l])
    );
  end

  for (genvar w = 0; w < N; w++) begin : g_cw
    for (genvar b = 0; b < N; b++) begin : g_cb
      localparam logic [IW-1:0] WI = IW'(w);
      localparam logic [IW-1:0] BI = IW'(b);
      assign clr_bits[w][b] = fire &&
        ((dir == DIR_COL) ? (lane_hit[w] && lane_b[w] == BI)
                          : (lane_hit[b] && lane_w[b] == WI));
    end
  end

  hbt_sum #(.N(N), .SW(SW)) u_sum (
    .terms (lane_term),
    .total (step_sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      act_q    <= '0;
      acc_q    <= '0;
      loaded_q <= 1'b0;
    end else if (start) begin
      mask_q   <= wt_in;
      act_q    <= act_in;
      acc_q    <= '0;
      loaded_q <= 1'b1;
    end else if (fire) begin
      mask_q   <= mask_q & ~clr_bits;
      acc_q    <= acc_q + step_sum;
    end
  end
endmodule

// File: rtl/hbt_checker.sv
module hbt_checker #(
  parameter int N  = 16,
  parameter int SW = 40,
  localparam int IW = $clog2(N)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           md_valid,
  input logic           md_ready,
  input logic           md_dir,
  input logic [IW-1:0]  md_idx,
  input logic [SW-1:0]  acc_out,
  input logic           done,
  input logic [N*N-1:0] mask,
  input logic [N*N-1:0] clr
);
  logic fire_c;
  assign fire_c = md_valid && md_ready;

  function automatic logic [N-1:0] column_of(input logic [N*N-1:0] m,
                                             input logic [IW-1:0] j);
    logic [N-1:0] c;
    for (int w = 0; w < N; w++) c[w] = m[w*N + int'(j)];
    return c;
  endfunction

  function automatic logic [N-1:0] row_of(input logic [N*N-1:0] m,
                                          input logic [IW-1:0] r);
    return m[int'(r)*N +: N];
  endfunction

  // R1
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (acc_out == '0));

  // R1
  start_blocks_md_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !md_ready);

  // R2
  col_line_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_c && !md_dir) |=> (column_of(mask, $past(md_idx)) == '0));

  // R3
  row_line_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_c && md_dir) |=> (row_of(mask, $past(md_idx)) == '0));

  // R6
  clear_only_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_c |-> ((clr & ~mask) == '0));

  // R7
  done_refuses_md_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !md_ready);

  // R8
  every_entry_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_c |=> ($countones(mask) < $past($countones(mask))));

  // R10
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire_c && !start) |=> $stable(acc_out));
endmodule

bind hybrid_bitskip_tile hbt_checker #(.N(N), .SW(SW)) u_hbt_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .md_valid (md_valid),
  .md_ready (md_ready),
  .md_dir   (md_dir),
  .md_idx   (md_idx),
  .acc_out  (acc_out),
  .done     (done),
  .mask     (mask_q),
  .clr      (clr_bits)
);

// File: tb/hybrid_bitskip_tile_bench.sv
module hybrid_bitskip_tile_bench;
  localparam int N  = 16;
  localparam int AW = 16;
  localparam int SW = 40;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [N*N-1:0] wt_in = '0;
  logic [N*AW-1:0] act_in = '0;
  logic           md_valid = 1'b0;
  logic           md_ready;
  logic           md_dir = 1'b0;
  logic [3:0]     md_idx = '0;
  logic [SW-1:0]  acc_out;
  logic           done;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [15:0] w_a [N];
  logic [15:0] a_a [N];

  hybrid_bitskip_tile u_hybrid_bitskip_tile (
    .clk(clk), .rst_n(rst_n), .start(start), .wt_in(wt_in), .act_in(act_in),
    .md_valid(md_valid), .md_ready(md_ready), .md_dir(md_dir), .md_idx(md_idx),
    .acc_out(acc_out), .done(done)
  );

  always #5 clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint ref_dot();
    longint s = 0;
    for (int i = 0; i < N; i++) s += longint'(a_a[i]) * longint'(w_a[i]);
    return s;
  endfunction

  function automatic int set_bits();
    int c = 0;
    for (int i = 0; i < N; i++) c += $countones(w_a[i]);
    return c;
  endfunction

  task automatic clear_tile();
    for (int i = 0; i < N; i++) begin w_a[i] = '0; a_a[i] = '0; end
  endtask

  task automatic load();
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      wt_in[i*16 +: 16]  = w_a[i];
      act_in[i*16 +: 16] = a_a[i];
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // offers one entry and returns at the negedge after the edge that took it
  task automatic entry(input bit d, input int idx);
    md_valid = 1'b1;
    md_dir   = d;
    md_idx   = 4'(idx);
    @(negedge clk);
    md_valid = 1'b0;
  endtask

  task automatic random_run(input string tag);
    int taken = 0;
    int bits = set_bits();
    load();
    for (int k = 0; k < 400 && !done; k++) begin
      md_valid = 1'b1;
      md_dir   = 1'($urandom_range(0, 1));
      md_idx   = 4'($urandom_range(0, 15));
      #1;
      if (md_ready) taken++;
      @(negedge clk);
    end
    md_valid = 1'b0;
    chk(done == 1'b1, {"R7 done ", tag}, done, 1);
    chk(acc_out == SW'(ref_dot()), {"R6 sum ", tag}, acc_out, ref_dot());
    chk(taken <= bits && (bits == 0 || taken >= (bits + N - 1) / N),
        {"R6 entries ", tag}, taken, bits);
  endtask

  initial begin
    logic [SW-1:0] hold;
    clear_tile();
    repeat (3) @(negedge clk);
    chk(done == 0 && md_ready == 0 && acc_out == 0, "R1 reset", {done, md_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 then R4: column 1 is the main line, then a pivot takes bit 0
    clear_tile();
    w_a[0] = 16'b11; w_a[1] = 16'b10; a_a[0] = 1; a_a[1] = 100;
    load();
    chk(acc_out == 0, "R1 cleared after start", acc_out, 0);
    entry(1'b0, 1);
    chk(acc_out == 202, "R2 column main line", acc_out, 202);
    chk(done == 0, "R2 not yet done", done, 0);
    entry(1'b0, 1);
    chk(acc_out == 203, "R4 column pivot to low bit", acc_out, 203);
    chk(done == 1, "R7 done after last bit", done, 1);

    // R7: entries after done are ignored
    hold = acc_out;
    md_valid = 1'b1; md_dir = 1'b1; md_idx = 4'd0;
    #1;
    chk(md_ready == 0, "R7 ready low when done", md_ready, 0);
    repeat (3) @(negedge clk);
    md_valid = 1'b0;
    chk(acc_out == hold, "R7 acc unchanged when done", acc_out, hold);

    // R3: a dense row, the main line blocks the pivot onto weight 4
    clear_tile();
    w_a[3] = 16'hFFFF; w_a[4] = 16'h0020; a_a[3] = 1; a_a[4] = 10;
    load();
    entry(1'b1, 3);
    chk(acc_out == 65535, "R3 row main line", acc_out, 65535);
    entry(1'b1, 3);
    chk(acc_out == 65855, "R5 row pivot after main", acc_out, 65855);
    chk(done == 1, "R3 done", done, 1);

    // R8 + R4: column 0 is empty for weight 0, which pivots to bit 1
    clear_tile();
    w_a[0] = 16'b1010; a_a[0] = 1;
    load();
    entry(1'b0, 0);
    chk(acc_out == 2, "R8 R4 empty column pivot", acc_out, 2);
    entry(1'b0, 3);
    chk(acc_out == 10, "R2 column finish", acc_out, 10);

    // R5: row 0 is empty, lane 0 takes weight 2 before weight 5
    clear_tile();
    w_a[2] = 16'h1; w_a[5] = 16'h1; a_a[2] = 3; a_a[5] = 7;
    load();
    entry(1'b1, 0);
    chk(acc_out == 3, "R5 lowest weight first", acc_out, 3);
    entry(1'b1, 0);
    chk(acc_out == 10, "R5 second pivot", acc_out, 10);

    // R10: no valid, no change
    clear_tile();
    w_a[7] = 16'h8001; a_a[7] = 5;
    load();
    repeat (4) @(negedge clk);
    chk(acc_out == 0 && done == 0, "R10 idle hold", acc_out, 0);

    // R9: all zero weights
    clear_tile();
    for (int i = 0; i < N; i++) a_a[i] = 16'hFFFF;
    load();
    chk(done == 1 && acc_out == 0, "R9 zero tile", {done, acc_out}, 1);

    // random patterns with random schedules (R6)
    void'($urandom(32'd7719));
    for (int t = 0; t < 12; t++) begin
      clear_tile();
      for (int i = 0; i < N; i++) begin
        a_a[i] = 16'($urandom);
        case (t % 4)
          0: w_a[i] = 16'($urandom);
          1: w_a[i] = 16'($urandom & $urandom & $urandom);
          2: w_a[i] = (i == t % N) ? 16'hFFFF : 16'($urandom & $urandom & $urandom & $urandom);
          default: w_a[i] = 16'(1 << (t % 16)) | 16'($urandom & $urandom & $urandom & $urandom);
        endcase
      end
      random_run($sformatf("pattern%0d", t));
    end

    // full matrix, maximum activations
    clear_tile();
    for (int i = 0; i < N; i++) begin w_a[i] = 16'hFFFF; a_a[i] = 16'hFFFF; end
    random_run("full");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule